// File: doc/BRIEF.md
# Memory ECC Error Capture Unit

This unit sits beside an ECC-protected memory controller and records what goes wrong on its accesses. Each access that fails reports an event made of a set of error-type flags, the failing 64-bit data word, the check code that came with it and the access address. The unit keeps sticky status flags per error type. It freezes a copy of the first ECC error's data, code and address. It also counts correctable (single-bit) errors against a programmable threshold, so that a flood of correctable errors raises status only once every N occurrences.

Software reaches the unit through a plain 32-bit register port with word addresses and a read latency of one cycle. Status flags clear when a 1 is written to them. A disable register keeps chosen error types from being recorded. An enable register selects which ECC flags drive the interrupt output. Three scratch registers hold the data-injection masks and the injection control word for the datapath. The block only stores them.

Top module: `ecc_err_capture`

Register word addresses (`reg_addr`): 0 status, 1 detect-disable, 2 interrupt-enable, 3 correctable-error management, 4 configuration, 5 captured data bits 63:32, 6 captured data bits 31:0, 7 captured address bits 31:0, 8 captured address upper bits, 9 captured check code, 10 injection mask high, 11 injection mask low, 12 injection control. Event and status bit layout: bit 0 single-bit (correctable), bit 1 multi-bit (uncorrectable), bits 2 and up are the other error types.

## Requirements
- R1: After synchronous reset every register reads zero, except the management register, which reads 0x00010000 (threshold 1, count 0), and `irq` is low.
- R2: Status bit 0 (single-bit), bit 1 (multi-bit) and bits 2..N_OTHER+1 (other types) are sticky: once set, a bit stays set until software clears it.
- R3: Writing the status register clears every bit written as 1 and leaves the other bits alone, so writing 0xFFFFFFFF clears them all. An event that sets a bit in the same cycle as a clear wins.
- R4: A 1 in detect-disable bit i keeps event flag i from setting status bit i. A disabled single-bit flag also does not advance the count.
- R5: The management register holds the threshold in bits 23:16 and the single-bit count in bits 7:0, and both can be written. Each enabled single-bit event computes count+1. If that value is at or above the threshold, status bit 0 is set and the count returns to 0. Otherwise the count takes that value. A threshold of 0 or 1 therefore flags every correctable error.
- R6: The interrupt-enable register has bit 0 for single-bit and bit 1 for multi-bit. `irq` is high one cycle after any status bit with a set enable is set, and low one cycle after none is. Other error types never drive `irq`.
- R7: Data, code and address are captured only by an event that sets status bit 0 or 1 while both of those bits are clear. The captured values hold until then.
- R8: Captured data reads as bits 63:32 at word 5 and bits 31:0 at word 6. The captured address reads as bits 31:0 at word 7, and its upper bits read zero-extended at word 8.
- R9: Configuration bit 0 selects the bus width. With 0 (64-bit), word 9 returns the captured code's low 8 bits. With 1 (32-bit), it returns the low 16 bits.
- R10: The two injection mask words and the injection control word read back the full 32 bits last written and affect no other register.
- R11: `reg_rdata` shows the register addressed in the previous cycle. Unmapped addresses 13..15 read zero, and writes to read-only words are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| ev_valid | input | 1 | Error event strobe |
| ev_flags | input | N_OTHER+2 | Error-type flags of the event |
| ev_data | input | 64 | Failing data word |
| ev_code | input | 16 | Check code read with the data |
| ev_addr | input | ADDR_W | Failing access address |
| irq | output | 1 | Registered interrupt request |

## Verification
The in-RTL assertions check the following on every cycle: status bits stay sticky unless a clear is written, a multi-bit flag only rises from an enabled event, the count steps by one or returns to zero, the captured words stay frozen while no capture is enabled, and the interrupt is low after a cycle with no enabled status. The bench's scenarios are needed for the rest. These are the exact threshold crossings for several threshold values, the first-error-wins capture across a clear, the bus-width masking of the check code, and the read-back of the injection and unmapped words. A reference model in the bench follows random mixes of events, clears, disables and threshold writes.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
  localparam int REG_AW = 4;
  localparam int DW     = 32;
  localparam int CNT_W  = 8;

  localparam logic [REG_AW-1:0] RA_STATUS  = 4'd0;
  localparam logic [REG_AW-1:0] RA_DISABLE = 4'd1;
  localparam logic [REG_AW-1:0] RA_IEN     = 4'd2;
  localparam logic [REG_AW-1:0] RA_MGMT    = 4'd3;
  localparam logic [REG_AW-1:0] RA_CFG     = 4'd4;
  localparam logic [REG_AW-1:0] RA_DHI     = 4'd5;
  localparam logic [REG_AW-1:0] RA_DLO     = 4'd6;
  localparam logic [REG_AW-1:0] RA_ALO     = 4'd7;
  localparam logic [REG_AW-1:0] RA_AEXT    = 4'd8;
  localparam logic [REG_AW-1:0] RA_CODE    = 4'd9;
  localparam logic [REG_AW-1:0] RA_INJ0    = 4'd10;
  localparam int N_INJ = 3;

  localparam int SBE_BIT = 0;
  localparam int MBE_BIT = 1;
endpackage

// File: rtl/ecc_sbe_counter.sv
module ecc_sbe_counter
  import ecc_cap_pkg::*;
#(
  parameter logic [CNT_W-1:0] THR_RESET = 8'd1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic             wr,
  input  logic [DW-1:0]    wdata,
  output logic [CNT_W-1:0] thr_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fire_o
);
  logic [CNT_W-1:0] cnt_q, thr_q;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  assign fire_o  = hit && (cnt_inc >= {1'b0, thr_q});
  assign thr_o   = thr_q;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      thr_q <= THR_RESET;
    end else if (wr) begin
      thr_q <= wdata[16 +: CNT_W];
      cnt_q <= wdata[0 +: CNT_W];
    end else if (hit) begin
      cnt_q <= fire_o ? '0 : cnt_inc[CNT_W-1:0];
    end
  end

  // R5
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (fire_o && !wr) |=> (cnt_q == '0));
  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && !fire_o && !wr) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R4
  cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!hit && !wr) |=> $stable(cnt_q));
endmodule

// File: rtl/ecc_capture_bank.sv
module ecc_capture_bank #(
  parameter int ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic [63:0]       data_i,
  input  logic [15:0]       code_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [63:0]       data_o,
  output logic [15:0]       code_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_o <= '0;
      code_o <= '0;
      addr_o <= '0;
    end else if (cap_en) begin
      data_o <= data_i;
      code_o <= code_i;
      addr_o <= addr_i;
    end
  end

  // R7
  cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cap_en |=> ($stable(data_o) && $stable(code_o) && $stable(addr_o)));
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
  import ecc_cap_pkg::*;
#(
  parameter int               N_OTHER   = 2,
  parameter int               ADDR_W    = 40,
  parameter logic [CNT_W-1:0] THR_RESET = 8'd1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [DW-1:0]       reg_wdata,
  output logic [DW-1:0]       reg_rdata,
  input  logic                ev_valid,
  input  logic [N_OTHER+1:0]  ev_flags,
  input  logic [63:0]         ev_data,
  input  logic [15:0]         ev_code,
  input  logic [ADDR_W-1:0]   ev_addr,
  output logic                irq
);
  localparam int NT    = N_OTHER + 2;
  localparam int EXT_W = ADDR_W - 32;

  logic [NT-1:0]     stat_q, dis_q, ev_ok, set_v, clr_v;
  logic [1:0]        ien_q;
  logic              narrow_q, irq_q;
  logic [DW-1:0]     inj_q [N_INJ];
  logic [CNT_W-1:0]  thr, cnt;
  logic              fire, cap_en;
  logic [63:0]       cap_data;
  logic [15:0]       cap_code;
  logic [ADDR_W-1:0] cap_addr;
  logic [DW-1:0]     rd_mux;

  assign ev_ok = ev_valid ? (ev_flags & ~dis_q) : '0;

  ecc_sbe_counter #(.THR_RESET(THR_RESET)) u_cnt (
    .clk(clk), .rst(rst), .hit(ev_ok[SBE_BIT]),
    .wr(reg_wr && reg_addr == RA_MGMT), .wdata(reg_wdata),
    .thr_o(thr), .cnt_o(cnt), .fire_o(fire)
  );

  assign set_v  = {ev_ok[NT-1:1], fire};
  assign clr_v  = (reg_wr && reg_addr == RA_STATUS) ? reg_wdata[NT-1:0] : '0;
  assign cap_en = (|set_v[MBE_BIT:SBE_BIT]) && (stat_q[MBE_BIT:SBE_BIT] == 2'b00);

  ecc_capture_bank #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst(rst), .cap_en(cap_en),
    .data_i(ev_data), .code_i(ev_code), .addr_i(ev_addr),
    .data_o(cap_data), .code_o(cap_code), .addr_o(cap_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q   <= '0;
      dis_q    <= '0;
      ien_q    <= '0;
      narrow_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr_v) | set_v;
      irq_q  <= |(stat_q[MBE_BIT:SBE_BIT] & ien_q);
      if (reg_wr && reg_addr == RA_DISABLE) dis_q    <= reg_wdata[NT-1:0];
      if (reg_wr && reg_addr == RA_IEN)     ien_q    <= reg_wdata[1:0];
      if (reg_wr && reg_addr == RA_CFG)     narrow_q <= reg_wdata[0];
    end
  end

  for (genvar k = 0; k < N_INJ; k++) begin : g_inj
    always_ff @(posedge clk) begin
      if (rst) inj_q[k] <= '0;
      else if (reg_wr && reg_addr == RA_INJ0 + REG_AW'(k)) inj_q[k] <= reg_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      RA_STATUS:  rd_mux[NT-1:0] = stat_q;
      RA_DISABLE: rd_mux[NT-1:0] = dis_q;
      RA_IEN:     rd_mux[1:0]    = ien_q;
      RA_MGMT:    rd_mux = {8'h00, thr, 8'h00, cnt};
      RA_CFG:     rd_mux[0] = narrow_q;
      RA_DHI:     rd_mux = cap_data[63:32];
      RA_DLO:     rd_mux = cap_data[31:0];
      RA_ALO:     rd_mux = cap_addr[31:0];
      RA_AEXT:    rd_mux[EXT_W-1:0] = cap_addr[ADDR_W-1:32];
      RA_CODE:    rd_mux[15:0] = narrow_q ? cap_code : {8'h00, cap_code[7:0]};
      default: begin
        for (int k = 0; k < N_INJ; k++)
          if (reg_addr == RA_INJ0 + REG_AW'(k)) rd_mux = inj_q[k];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  assign irq = irq_q;

  for (genvar b = 0; b < NT; b++) begin : g_sticky
    // R2
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (stat_q[b] && !clr_v[b]) |=> stat_q[b]);
  end

  // R4
  mbe_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_q[MBE_BIT]) |-> $past(ev_valid && ev_flags[MBE_BIT] && !dis_q[MBE_BIT]));
  // R6
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((stat_q[MBE_BIT:SBE_BIT] & ien_q) == 2'b00) |=> !irq);
  // R3
  clr_all_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == RA_STATUS && reg_wdata == 32'hFFFF_FFFF && !ev_valid)
      |=> (stat_q == '0));
endmodule

// File: tb/ecc_err_capture_test.sv
module ecc_err_capture_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ev_valid = 1'b0;
  logic [3:0]  ev_flags = '0;
  logic [63:0] ev_data = '0;
  logic [15:0] ev_code = '0;
  logic [39:0] ev_addr = '0;
  logic        irq;

  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  ecc_err_capture uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_valid(ev_valid),
    .ev_flags(ev_flags), .ev_data(ev_data), .ev_code(ev_code),
    .ev_addr(ev_addr), .irq(irq)
  );

  // reference model
  logic [3:0]  m_stat, m_dis;
  logic [1:0]  m_ien;
  logic [7:0]  m_thr, m_cnt;
  logic        m_narrow;
  logic [63:0] m_data;
  logic [15:0] m_code;
  logic [39:0] m_addr;
  logic [31:0] m_inj [3];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(logic [3:0] a);
    case (a)
      4'd0:  return {28'h0, m_stat};
      4'd1:  return {28'h0, m_dis};
      4'd2:  return {30'h0, m_ien};
      4'd3:  return {8'h0, m_thr, 8'h0, m_cnt};
      4'd4:  return {31'h0, m_narrow};
      4'd5:  return m_data[63:32];
      4'd6:  return m_data[31:0];
      4'd7:  return m_addr[31:0];
      4'd8:  return {24'h0, m_addr[39:32]};
      4'd9:  return m_narrow ? {16'h0, m_code} : {24'h0, m_code[7:0]};
      4'd10: return m_inj[0];
      4'd11: return m_inj[1];
      4'd12: return m_inj[2];
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(logic [3:0] a);
    case (a)
      4'd0: return "R2";  4'd1: return "R4";  4'd2: return "R6";
      4'd3: return "R5";  4'd4: return "R9";  4'd9: return "R9";
      4'd5, 4'd6, 4'd7, 4'd8: return "R8";
      4'd10, 4'd11, 4'd12: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic model_reset();
    m_stat = 0; m_dis = 0; m_ien = 0; m_thr = 8'd1; m_cnt = 0; m_narrow = 0;
    m_data = 0; m_code = 0; m_addr = 0;
    for (int k = 0; k < 3; k++) m_inj[k] = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a;
    @(negedge clk); v = reg_rdata;
  endtask

  task automatic rchk(logic [3:0] a, string req);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp_read(a));
  endtask

  task automatic wreg(logic [3:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
    case (a)
      4'd0: m_stat = m_stat & ~d[3:0];
      4'd1: m_dis = d[3:0];
      4'd2: m_ien = d[1:0];
      4'd3: begin m_thr = d[23:16]; m_cnt = d[7:0]; end
      4'd4: m_narrow = d[0];
      4'd10: m_inj[0] = d;
      4'd11: m_inj[1] = d;
      4'd12: m_inj[2] = d;
      default: ;
    endcase
  endtask

  task automatic ev(logic [3:0] f, logic [63:0] d, logic [15:0] c, logic [39:0] a);
    logic [3:0] ok, set;
    logic [8:0] n;
    @(negedge clk);
    ev_valid = 1; ev_flags = f; ev_data = d; ev_code = c; ev_addr = a;
    @(negedge clk); ev_valid = 0;
    ok = f & ~m_dis;
    set = {ok[3:1], 1'b0};
    if (ok[0]) begin
      n = {1'b0, m_cnt} + 9'd1;
      if (n >= {1'b0, m_thr}) begin set[0] = 1; m_cnt = 0; end
      else m_cnt = n[7:0];
    end
    if (set[1:0] != 0 && m_stat[1:0] == 0) begin
      m_data = d; m_code = c; m_addr = a;
    end
    m_stat = m_stat | set;
  endtask

  task automatic irq_chk(string req);
    @(negedge clk);
    chk(req, {31'h0, irq}, {31'h0, |(m_stat[1:0] & m_ien)});
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_0C0D));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    for (int a = 0; a < 13; a++) rchk(4'(a), "R1");
    chk("R1 irq", {31'h0, irq}, 32'h0);
    // R11 unmapped
    for (int a = 13; a < 16; a++) rchk(4'(a), "R11");
    // R11 writes to read-only capture words ignored
    wreg(4'd6, 32'hDEAD_BEEF); rchk(4'd6, "R11");

    // R10 injection registers
    wreg(4'd10, 32'hA5A5_0001); wreg(4'd11, 32'h0F0F_F0F0); wreg(4'd12, 32'h8000_0003);
    rchk(4'd10, "R10"); rchk(4'd11, "R10"); rchk(4'd12, "R10"); rchk(4'd0, "R10");

    // R5 threshold 3
    wreg(4'd3, 32'h0003_0000);
    ev(4'b0001, 64'h1111_2222_3333_4444, 16'h12AB, 40'h12_3456_7890);
    ev(4'b0001, 64'h5, 16'h5, 40'h5);
    rchk(4'd0, "R5"); rchk(4'd3, "R5");
    ev(4'b0001, 64'hCAFE_0000_0000_BEEF, 16'h34CD, 40'hAB_CDEF_0123);
    rchk(4'd0, "R5"); rchk(4'd3, "R5");
    // R7 R8 first capture at threshold crossing
    rchk(4'd5, "R8"); rchk(4'd6, "R8"); rchk(4'd7, "R8"); rchk(4'd8, "R8");
    // R9 code width
    rchk(4'd9, "R9"); wreg(4'd4, 1); rchk(4'd9, "R9"); wreg(4'd4, 0); rchk(4'd9, "R9");
    // R7 later multi-bit error does not overwrite capture
    ev(4'b0010, 64'hFFFF_FFFF_FFFF_FFFF, 16'hFFFF, 40'hFF_FFFF_FFFF);
    rchk(4'd6, "R7"); rchk(4'd0, "R2");
    // R6 interrupt
    wreg(4'd2, 32'h1); irq_chk("R6");
    wreg(4'd0, 32'h1); irq_chk("R6");
    wreg(4'd2, 32'h2); irq_chk("R6");
    // R3 clear all, then R7 new capture
    wreg(4'd0, 32'hFFFF_FFFF); rchk(4'd0, "R3"); irq_chk("R3");
    ev(4'b0100, 64'h77, 16'h77, 40'h77); irq_chk("R6");
    rchk(4'd6, "R7");
    ev(4'b0010, 64'h0123_4567_89AB_CDEF, 16'h00EE, 40'h01_0000_0042);
    rchk(4'd6, "R7"); rchk(4'd8, "R8"); irq_chk("R6");
    // R4 disable
    wreg(4'd0, 32'hF); wreg(4'd1, 32'h3); wreg(4'd3, 32'h0001_0000);
    ev(4'b0011, 64'h9, 16'h9, 40'h9);
    rchk(4'd0, "R4"); rchk(4'd3, "R4"); rchk(4'd6, "R4");
    wreg(4'd1, 32'h0);
    // R5 threshold 0 flags every error
    wreg(4'd3, 32'h0000_0000);
    ev(4'b0001, 64'hA, 16'hA, 40'hA); rchk(4'd0, "R5"); rchk(4'd3, "R5");
    // R3 event beats clear in same cycle
    @(negedge clk);
    reg_wr = 1; reg_addr = 4'd0; reg_wdata = 32'h2;
    ev_valid = 1; ev_flags = 4'b0010;
    @(negedge clk); reg_wr = 0; ev_valid = 0; m_stat[1] = 1'b1;
    rchk(4'd0, "R3");

    // random phase
    wreg(4'd0, 32'hF); wreg(4'd2, 32'h3);
    for (int i = 0; i < 300; i++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 60)
        ev(4'($urandom), {$urandom, $urandom}, 16'($urandom),
           {8'($urandom), $urandom});
      else if (r < 75) wreg(4'd0, $urandom);
      else if (r < 85) wreg(4'd3, {8'h0, 8'($urandom % 5), 16'h0});
      else if (r < 93) wreg(4'd1, {28'h0, 4'($urandom) & 4'h5});
      else wreg(4'd4, {31'h0, 1'($urandom)});
      rchk(4'd0, "R2"); rchk(4'd3, "R5"); rchk(4'd6, "R7");
      irq_chk("R6");
    end
    for (int a = 0; a < 16; a++) rchk(4'(a), req_of(4'(a)));

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule